// File: doc/BRIEF.md
# SPI Buffer Command Slave

This block is the serial front end of a page-buffered flash device. It watches an SPI mode-0 link (SCK, CS_n, SI, SO) with a fast system clock. It decodes an 8-bit opcode, collects the address bytes that follow, and serves two external 1024-byte SRAM buffers through a simple synchronous port: a write strobe, or a read strobe whose data comes back one clock later. It also answers status reads and identification reads. It handles a deep power-down state, which only a resume opcode can leave. The non-volatile array and its program and erase engines sit outside the block. They appear here only as a busy input, which the status byte reports.

The serial inputs are assumed to be already synchronous to `clk`. SCK must stay high and stay low for at least 4 `clk` cycles in each phase. The block acts only on whole bytes, so a CS_n rise in the middle of a byte leaves no trace. A buffer transfer that runs past location 1023 wraps to location 0 and continues.

Top module: `spi_buf_slave`

## Requirements
- R1: SPI mode 0, most significant bit first: SI is sampled on rising SCK and SO changes only on falling SCK. A command starts when CS_n falls. SO is not driven (so_oe=0) while CS_n is high, during the opcode, address and dummy bytes, and out of reset.
- R2: Opcode 84h writes buffer 1 (mem_sel=0) and opcode 87h writes buffer 2 (mem_sel=1). Three address bytes follow: 14 ignored bits, then a 10-bit location. Each following complete byte is written to the next location in turn. The block never strobes write and read together.
- R3: Buffer writes and buffer reads wrap from location 1023 to location 0 and continue the transfer.
- R4: Opcode D4h reads buffer 1 and opcode D6h reads buffer 2. They take the same three address bytes as a write, then one dummy byte. The first data bit appears on the falling SCK after the dummy byte, and later bytes come from consecutive locations. Each read strobe lasts one cycle.
- R5: Opcode D7h returns a status byte, repeated for as long as bytes are clocked. Bit 7 is 1 when busy_i is low and 0 when it is high. Bits 6..1 are the parameter STATUS_MID. Bit 0 is page_bin_i. Each byte samples busy_i again.
- R6: Opcode 9Fh returns the ID_LEN bytes of ID_WORD, most significant byte first, then 00h for every later byte.
- R7: Opcode B9h enters power-down only when CS_n rises right after its eighth bit. Any extra SCK rise before CS_n rises cancels it.
- R8: While powered down, every opcode except ABh is ignored: SO is not driven and neither SRAM strobe fires.
- R9: Opcode ABh followed at once by a CS_n rise leaves power-down, after which all commands work again.
- R10: A CS_n rise in the middle of a byte discards the partial byte (no SRAM write) and returns the decoder to idle, ready for the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, synchronous to clk |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so; 0 means high impedance |
| busy_i | input | 1 | Array engine busy flag |
| page_bin_i | input | 1 | Page-size setting shown in status bit 0 |
| mem_we | output | 1 | Buffer write strobe |
| mem_re | output | 1 | Buffer read strobe; data is expected on mem_rdata one cycle later |
| mem_sel | output | 1 | Buffer select, 0 for buffer 1 and 1 for buffer 2 |
| mem_addr | output | ADDR_W | Buffer location |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read back from the SRAM |

## Verification
A bit counter that has slipped by one shows up in the very next byte. The first status or ID byte comes back rotated, or a buffer write lands one location off, which a read-back of the neighbouring location exposes. A location register that does not wrap corrupts location 0 within the second byte after location 1023. A power-down flag in the wrong state shows at once, in the next command: a status read either drives SO while the block should be asleep, or stays silent after a resume. A mid-byte CS_n rise that is not cleared leaves a stray write, which is visible in a later read-back, and garbles the opcode of the following command.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    typedef enum logic [3:0] {
        PH_OPC,
        PH_ADDR,
        PH_DUMMY,
        PH_WDATA,
        PH_RDATA,
        PH_STAT,
        PH_ID,
        PH_PDARM,
        PH_RESARM,
        PH_IGNORE
    } phase_e;

    localparam logic [7:0] OP_WR_B1  = 8'h84;
    localparam logic [7:0] OP_WR_B2  = 8'h87;
    localparam logic [7:0] OP_RD_B1  = 8'hD4;
    localparam logic [7:0] OP_RD_B2  = 8'hD6;
    localparam logic [7:0] OP_STATUS = 8'hD7;
    localparam logic [7:0] OP_ID     = 8'h9F;
    localparam logic [7:0] OP_PDOWN  = 8'hB9;
    localparam logic [7:0] OP_RESUME = 8'hAB;
endpackage

// File: rtl/sbs_edge.sv
module sbs_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic prev_q, prev_d;

    always_comb prev_d = sig;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= prev_d;
    end

    assign rise = sig & ~prev_q;
    assign fall = ~sig & prev_q;
endmodule

// File: rtl/sbs_tx_shift.sv
module sbs_tx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         so
);
    typedef struct packed {
        logic [W-1:0] sh;
        logic         bit_out;
    } tx_t;

    tx_t tx_q, tx_d;

    always_comb begin
        tx_d = tx_q;
        if (load) begin
            tx_d.sh = load_val;
        end else if (shift) begin
            tx_d.bit_out = tx_q.sh[W-1];
            tx_d.sh      = {tx_q.sh[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign so = tx_q.bit_out;
endmodule

// File: rtl/spi_buf_slave.sv
module spi_buf_slave
    import sbs_pkg::*;
#(
    parameter int                  ADDR_W     = 10,
    parameter int                  ADDR_BYTES = 3,
    parameter logic [5:0]          STATUS_MID = 6'b101101,
    parameter int                  ID_LEN     = 4,
    parameter logic [8*ID_LEN-1:0] ID_WORD    = 32'hA53C0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    output logic              so,
    output logic              so_oe,
    input  logic              busy_i,
    input  logic              page_bin_i,
    output logic              mem_we,
    output logic              mem_re,
    output logic              mem_sel,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    localparam int CNT_MAX = (ID_LEN > ADDR_BYTES) ? ID_LEN : ADDR_BYTES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        phase_e            phase;
        logic [2:0]        bit_cnt;
        logic [CNT_W-1:0]  byte_cnt;
        logic [7:0]        rx;
        logic [ADDR_W-1:0] addr;
        logic              sel;
        logic              rd;
        logic              pdown;
        logic              load_pend;
        logic              cs_prev;
    } st_t;

    st_t st_q, st_d;

    logic       sck_rise, sck_fall;
    logic       tx_load, tx_shift;
    logic [7:0] tx_val;
    logic [7:0] nb;
    logic       byte_done;
    logic       cs_rise;
    logic       tx_phase;
    logic       pdown_w;

    function automatic logic [7:0] id_byte(input logic [CNT_W-1:0] idx);
        logic [7:0] r;
        r = 8'h00;
        for (int k = 0; k < ID_LEN; k++) begin
            if (idx == CNT_W'(k)) r = ID_WORD[8*(ID_LEN-1-k) +: 8];
        end
        return r;
    endfunction

    function automatic logic [7:0] status_byte(input logic busy, input logic pbin);
        return {~busy, STATUS_MID, pbin};
    endfunction

    sbs_edge #(.RST_VAL(1'b0)) u_sck_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (sck),
        .rise (sck_rise),
        .fall (sck_fall)
    );

    sbs_tx_shift #(.W(8)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tx_load),
        .load_val(tx_val),
        .shift   (tx_shift),
        .so      (so)
    );

    assign nb        = {st_q.rx[6:0], si};
    assign byte_done = (st_q.bit_cnt == 3'd7);
    assign cs_rise   = cs_n & ~st_q.cs_prev;
    assign tx_phase  = (st_q.phase == PH_STAT) || (st_q.phase == PH_ID) ||
                       (st_q.phase == PH_RDATA);
    assign so_oe     = ~cs_n & tx_phase;
    assign pdown_w   = st_q.pdown;

    always_comb begin
        st_d           = st_q;
        st_d.cs_prev   = cs_n;
        st_d.load_pend = 1'b0;
        tx_load        = 1'b0;
        tx_val         = 8'h00;
        tx_shift       = 1'b0;
        mem_we         = 1'b0;
        mem_re         = 1'b0;
        mem_sel        = st_q.sel;
        mem_addr       = st_q.addr;
        mem_wdata      = nb;

        if (st_q.load_pend) begin
            tx_load = 1'b1;
            tx_val  = mem_rdata;
        end

        if (cs_n) begin
            if (cs_rise && st_q.bit_cnt == 3'd0) begin
                if (st_q.phase == PH_PDARM)  st_d.pdown = 1'b1;
                if (st_q.phase == PH_RESARM) st_d.pdown = 1'b0;
            end
            st_d.phase     = PH_OPC;
            st_d.bit_cnt   = 3'd0;
            st_d.byte_cnt  = '0;
            st_d.rx        = 8'h00;
            st_d.load_pend = 1'b0;
        end else begin
            if (sck_fall && tx_phase) tx_shift = 1'b1;
            if (sck_rise) begin
                st_d.bit_cnt = st_q.bit_cnt + 3'd1;
                st_d.rx      = nb;
                case (st_q.phase)
                    PH_OPC: begin
                        if (byte_done) begin
                            if (st_q.pdown) begin
                                st_d.phase = (nb == OP_RESUME) ? PH_RESARM : PH_IGNORE;
                            end else begin
                                case (nb)
                                    OP_WR_B1, OP_WR_B2, OP_RD_B1, OP_RD_B2: begin
                                        st_d.phase    = PH_ADDR;
                                        st_d.byte_cnt = '0;
                                        st_d.sel      = (nb == OP_WR_B2) || (nb == OP_RD_B2);
                                        st_d.rd       = (nb == OP_RD_B1) || (nb == OP_RD_B2);
                                    end
                                    OP_STATUS: begin
                                        st_d.phase = PH_STAT;
                                        tx_load    = 1'b1;
                                        tx_val     = status_byte(busy_i, page_bin_i);
                                    end
                                    OP_ID: begin
                                        st_d.phase    = PH_ID;
                                        tx_load       = 1'b1;
                                        tx_val        = id_byte('0);
                                        st_d.byte_cnt = CNT_W'(1);
                                    end
                                    OP_PDOWN: st_d.phase = PH_PDARM;
                                    default:  st_d.phase = PH_IGNORE;
                                endcase
                            end
                        end
                    end
                    PH_ADDR: begin
                        st_d.addr = {st_q.addr[ADDR_W-2:0], si};
                        if (byte_done) begin
                            if (st_q.byte_cnt == CNT_W'(ADDR_BYTES - 1)) begin
                                st_d.phase    = st_q.rd ? PH_DUMMY : PH_WDATA;
                                st_d.byte_cnt = '0;
                            end else begin
                                st_d.byte_cnt = st_q.byte_cnt + CNT_W'(1);
                            end
                        end
                    end
                    PH_DUMMY, PH_RDATA: begin
                        if (byte_done) begin
                            st_d.phase     = PH_RDATA;
                            mem_re         = 1'b1;
                            st_d.addr      = st_q.addr + ADDR_W'(1);
                            st_d.load_pend = 1'b1;
                        end
                    end
                    PH_WDATA: begin
                        if (byte_done) begin
                            mem_we    = 1'b1;
                            st_d.addr = st_q.addr + ADDR_W'(1);
                        end
                    end
                    PH_STAT: begin
                        if (byte_done) begin
                            tx_load = 1'b1;
                            tx_val  = status_byte(busy_i, page_bin_i);
                        end
                    end
                    PH_ID: begin
                        if (byte_done) begin
                            tx_load = 1'b1;
                            tx_val  = id_byte(st_q.byte_cnt);
                            if (st_q.byte_cnt < CNT_W'(ID_LEN))
                                st_d.byte_cnt = st_q.byte_cnt + CNT_W'(1);
                        end
                    end
                    PH_PDARM, PH_RESARM: st_d.phase = PH_IGNORE;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.phase   <= PH_OPC;
            st_q.cs_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/spi_buf_slave_chk.sv
module spi_buf_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sck,
    input logic so,
    input logic so_oe,
    input logic mem_we,
    input logic mem_re,
    input logic pdown
);
    // R1: no drive while deselected
    assert_so_hiz_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !so_oe);

    // R1: serial output only moves after SCK went low
    assert_so_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(so) |-> $past(!sck));

    // R2: the two buffer strobes never coincide
    assert_mem_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R4: one read strobe per byte
    assert_re_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> !mem_re);

    // R8: asleep means silent
    assert_pd_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pdown |-> (!mem_we && !mem_re && !so_oe));
endmodule

bind spi_buf_slave spi_buf_slave_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .sck   (sck),
    .so    (so),
    .so_oe (so_oe),
    .mem_we(mem_we),
    .mem_re(mem_re),
    .pdown (pdown_w)
);

// File: tb/tb_spi_buf_slave.sv
module tb_spi_buf_slave;
    localparam int         CLK_PERIOD = 10;
    localparam int         HALF       = 4;
    localparam logic [5:0] MID        = 6'b101101;
    localparam logic [31:0] IDW       = 32'hA53C0100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic       busy = 1'b0, pbin = 1'b1;
    logic       so, so_oe, mem_we, mem_re, mem_sel;
    logic [9:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata = 8'h00;

    int tests = 0, fails = 0;
    int we_cnt = 0, re_cnt = 0;
    bit done = 0;

    logic [7:0] sram    [0:1][0:1023];
    logic [7:0] exp_mem [0:1][0:1023];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_buf_slave #(.ADDR_W(10), .ADDR_BYTES(3), .STATUS_MID(MID), .ID_LEN(4), .ID_WORD(IDW)) dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .so(so), .so_oe(so_oe),
        .busy_i(busy), .page_bin_i(pbin), .mem_we(mem_we), .mem_re(mem_re), .mem_sel(mem_sel),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            sram[mem_sel][mem_addr] <= mem_wdata;
            we_cnt <= we_cnt + 1;
        end
        if (mem_re) begin
            mem_rdata <= sram[mem_sel][mem_addr];
            re_cnt <= re_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                        output logic oe_any, output logic oe_all);
        rx = 8'h00; oe_any = 1'b0; oe_all = 1'b1;
        for (int b = 7; b >= 0; b--) begin
            si = tx[b];
            tick(HALF);
            rx[b] = so;
            oe_any |= so_oe;
            oe_all &= so_oe;
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic sel_on();
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic sel_off();
        tick(HALF);
        cs_n = 1'b1;
        tick(HALF);
        check(so_oe == 1'b0, "R1 hiz after deselect", so_oe, 0);
    endtask

    function automatic logic [7:0] stat(input logic b, input logic p);
        return {~b, MID, p};
    endfunction

    task automatic send_addr(input logic [9:0] a, input bit dc_ones);
        logic [7:0] r; logic oa, ol;
        xfer(dc_ones ? 8'hFF : 8'h00, r, oa, ol);
        check(oa == 1'b0, "R1 hiz in address", oa, 0);
        xfer({dc_ones ? 6'h3F : 6'h00, a[9:8]}, r, oa, ol);
        xfer(a[7:0], r, oa, ol);
        check(oa == 1'b0, "R1 hiz in address", oa, 0);
    endtask

    task automatic write_buf(input int sel, input logic [9:0] a, input int n,
                             input logic [7:0] seed, input bit dc_ones);
        logic [7:0] r; logic oa, ol;
        sel_on();
        xfer(sel ? 8'h87 : 8'h84, r, oa, ol);
        send_addr(a, dc_ones);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = seed + 8'(i * 37);
            xfer(d, r, oa, ol);
            exp_mem[sel][10'(a + 10'(i))] = d;
        end
        sel_off();
    endtask

    task automatic read_buf(input int sel, input logic [9:0] a, input int n, input string req);
        logic [7:0] r; logic oa, ol;
        sel_on();
        xfer(sel ? 8'hD6 : 8'hD4, r, oa, ol);
        check(oa == 1'b0, "R1 hiz in opcode", oa, 0);
        send_addr(a, 1'b1);
        xfer(8'h00, r, oa, ol);
        check(oa == 1'b0, "R4 hiz in dummy", oa, 0);
        for (int i = 0; i < n; i++) begin
            logic [9:0] ai;
            ai = 10'(a + 10'(i));
            xfer(8'h00, r, oa, ol);
            check(r == exp_mem[sel][ai], req, r, exp_mem[sel][ai]);
            check(ol == 1'b1, "R4 SO driven in data", ol, 1);
        end
        sel_off();
    endtask

    task automatic status_frame(input int n, input logic exp_drive, input string req);
        logic [7:0] r; logic oa, ol;
        sel_on();
        xfer(8'hD7, r, oa, ol);
        check(oa == 1'b0, "R1 hiz in opcode", oa, 0);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, r, oa, ol);
            if (exp_drive) begin
                check(r == stat(busy, pbin), req, r, stat(busy, pbin));
                check(ol == 1'b1, req, ol, 1);
            end else begin
                check(oa == 1'b0, req, oa, 0);
            end
        end
        sel_off();
    endtask

    task automatic id_frame(input logic exp_drive, input string req);
        logic [7:0] r; logic oa, ol;
        sel_on();
        xfer(8'h9F, r, oa, ol);
        for (int i = 0; i < 6; i++) begin
            logic [7:0] e;
            e = (i < 4) ? IDW[8*(3-i) +: 8] : 8'h00;
            xfer(8'h00, r, oa, ol);
            if (exp_drive) check(r == e && ol, req, r, e);
            else           check(oa == 1'b0, req, oa, 0);
        end
        sel_off();
    endtask

    task automatic op_frame(input logic [7:0] op, input int extra);
        logic [7:0] r; logic oa, ol;
        sel_on();
        xfer(op, r, oa, ol);
        for (int i = 0; i < extra; i++) xfer(8'h00, r, oa, ol);
        sel_off();
    endtask

    initial begin
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 1024; a++) begin
                sram[s][a]    = 8'(a ^ (s * 8'h5A));
                exp_mem[s][a] = 8'(a ^ (s * 8'h5A));
            end
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(3);
        check(so_oe == 1'b0 && mem_we == 1'b0 && mem_re == 1'b0, "R1 reset state",
              {so_oe, mem_we, mem_re}, 0);

        // R5: status, ready and busy, repeated
        status_frame(3, 1'b1, "R5 status ready");
        busy = 1'b1; pbin = 1'b0;
        status_frame(2, 1'b1, "R5 status busy");
        busy = 1'b0; pbin = 1'b1;
        begin
            logic [7:0] r; logic oa, ol;
            sel_on();
            xfer(8'hD7, r, oa, ol);
            xfer(8'h00, r, oa, ol);
            check(r == stat(1'b0, 1'b1), "R5 live byte0", r, stat(1'b0, 1'b1));
            busy = 1'b1;
            xfer(8'h00, r, oa, ol);
            check(r == stat(1'b0, 1'b1), "R5 live byte1", r, stat(1'b0, 1'b1));
            xfer(8'h00, r, oa, ol);
            check(r == stat(1'b1, 1'b1), "R5 live byte2 busy", r, stat(1'b1, 1'b1));
            sel_off();
            busy = 1'b0;
        end

        // R6: identification
        id_frame(1'b1, "R6 id bytes");

        // R2 / R3 / R4: buffer traffic with wrap
        write_buf(0, 10'd1021, 5, 8'h11, 1'b1);
        read_buf(0, 10'd1021, 5, "R3 wrap read buf1");
        read_buf(0, 10'd1020, 1, "R2 neighbour untouched");
        write_buf(1, 10'd5, 3, 8'hC3, 1'b0);
        read_buf(1, 10'd4, 5, "R2 buf2 write");
        read_buf(0, 10'd4, 5, "R4 buf1 unaffected by buf2");

        // R10: partial byte discarded
        begin
            logic [7:0] r; logic oa, ol;
            int wc;
            wc = we_cnt;
            sel_on();
            xfer(8'h84, r, oa, ol);
            send_addr(10'd100, 1'b0);
            xfer(8'h5A, r, oa, ol);
            exp_mem[0][100] = 8'h5A;
            for (int b = 0; b < 4; b++) begin
                si = 1'b1; tick(HALF); sck = 1'b1; tick(HALF); sck = 1'b0;
            end
            sel_off();
            check(we_cnt == wc + 1, "R10 partial byte not written", we_cnt - wc, 1);
        end
        read_buf(0, 10'd100, 2, "R10 partial discard readback");
        status_frame(1, 1'b1, "R10 decoder idle after abort");

        // R7: extra byte cancels power-down
        op_frame(8'hB9, 1);
        status_frame(1, 1'b1, "R7 cancelled power-down");

        // R7 / R8: real power-down
        op_frame(8'hB9, 0);
        status_frame(2, 1'b0, "R8 status ignored asleep");
        id_frame(1'b0, "R8 id ignored asleep");
        begin
            int wc, rc;
            wc = we_cnt; rc = re_cnt;
            write_buf(0, 10'd200, 2, 8'h77, 1'b0);
            exp_mem[0][200] = 8'(200);
            exp_mem[0][201] = 8'(201);
            begin
                logic [7:0] r; logic oa, ol;
                sel_on();
                xfer(8'hD4, r, oa, ol);
                send_addr(10'd200, 1'b0);
                xfer(8'h00, r, oa, ol);
                xfer(8'h00, r, oa, ol);
                check(oa == 1'b0, "R8 read ignored asleep", oa, 0);
                sel_off();
            end
            check(we_cnt == wc && re_cnt == rc, "R8 no SRAM access asleep",
                  (we_cnt - wc) + (re_cnt - rc), 0);
        end

        // R9: resume
        op_frame(8'hAB, 0);
        status_frame(2, 1'b1, "R9 status after resume");
        id_frame(1'b1, "R9 id after resume");
        read_buf(0, 10'd200, 2, "R9 buffer intact after resume");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        done = 1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule